// File: doc/BRIEF.md
# Operand Buffer Handshake Scoreboard

This block keeps the bookkeeping for a small ring of data buffers. An instruction look-ahead unit and an arithmetic execution unit share these buffers. The look-ahead side claims buffers in program order. It claims a buffer either to prefetch an operand from memory or to reserve a slot for a result that will later be written to memory. The execution side walks the same ring in the same order. It either takes the prefetched operand or deposits its result. A buffer that holds a deposited result raises a memory write request. When that write is acknowledged, the buffer becomes free again. The look-ahead side stalls whenever the buffer it would claim next is still in use.

Each buffer carries a two-bit indicator. The upper bit means "data present" and the lower bit means "result slot reserved". Each side has its own cyclic pointer. A side's pointer advances only when that side completes an action on its current buffer. The buffer contents and the memory timing are outside this block.

Top module: `obs_scoreboard`

## Requirements
- R1: While `rst_n` is low, both pointers read 0, every indicator in `buf_state` reads 00 and `mem_wr_req` is low.
- R2: An accepted look-ahead load (`la_valid`=1, `la_write`=0, `la_ready`=1) sets the indicator of buffer `la_ptr` to 10 (data present) at the next clock edge.
- R3: An accepted look-ahead reservation (`la_valid`=1, `la_write`=1, `la_ready`=1) sets the indicator of buffer `la_ptr` to 01 (slot reserved) at the next clock edge.
- R4: `la_ready` is high only when the indicator of buffer `la_ptr` is 00. A look-ahead request made while it is low changes neither the pointer nor any indicator.
- R5: An execution-side consume (`ex_valid`=1, `ex_result`=0) on a buffer whose indicator is 10 returns that indicator to 00.
- R6: An execution-side deposit (`ex_valid`=1, `ex_result`=1) on a buffer whose indicator is 01 sets it to 11.
- R7: An execution-side request whose kind does not match the indicator of buffer `ex_ptr` (`ex_ready` low) changes neither `ex_ptr` nor any indicator.
- R8: `mem_wr_req` is high while any indicator is 11. `mem_wr_idx` then names the first buffer holding 11 when the ring is searched forward, cyclically, from `la_ptr`. That buffer is the oldest pending result.
- R9: A write acknowledge (`mem_wr_ack`=1 while `mem_wr_req`=1) returns the indicator of buffer `mem_wr_idx` to 00 at the next edge.
- R10: A look-ahead action, an execution action and a write acknowledge in the same cycle all take effect together.
- R11: Each pointer steps by one, wrapping from 3 to 0, exactly when its side's request is accepted.
- Indicator field i of `buf_state` occupies bits [2i+1:2i]. Bit 2i+1 is the data bit and bit 2i is the reserve bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| la_valid | input | 1 | Look-ahead side wants to claim its next buffer |
| la_write | input | 1 | 1: reserve for a result, 0: load an operand |
| la_ready | output | 1 | Next look-ahead buffer is free |
| la_ptr | output | 2 | Buffer index for the look-ahead side |
| ex_valid | input | 1 | Execution side acts on its current buffer |
| ex_result | input | 1 | 1: deposit a result, 0: consume an operand |
| ex_ready | output | 1 | Current execution buffer matches the requested action |
| ex_ptr | output | 2 | Buffer index for the execution side |
| mem_wr_ack | input | 1 | Memory has taken the requested write |
| mem_wr_req | output | 1 | A result buffer waits for write-back |
| mem_wr_idx | output | 2 | Buffer to write back |
| buf_state | output | 8 | All indicators, two bits per buffer |

## Verification
The outputs `la_ready`, `ex_ready`, `mem_wr_req` and `mem_wr_idx` are combinational from the current indicators and pointers, so they are valid in the same cycle. Indicator and pointer changes caused by an accepted request land one clock edge later. The bench therefore drives each stimulus at a falling edge and compares pointers, indicators and the write request at the next falling edge, after exactly one rising edge. The write-back choice is checked in that same sample, because it follows directly from the updated state.

// File: rtl/obs_pkg.sv
package obs_pkg;

  typedef logic [1:0] ind_t;

  localparam ind_t IND_FREE = 2'b00;
  localparam ind_t IND_RSVD = 2'b01;
  localparam ind_t IND_OPND = 2'b10;
  localparam ind_t IND_DONE = 2'b11;

  // a buffer may be claimed only when neither bit is set
  function automatic logic ind_is_free(input ind_t v);
    return v == IND_FREE;
  endfunction

  // reserved slot holding its result: waits for memory write
  function automatic logic ind_wants_wb(input ind_t v);
    return v == IND_DONE;
  endfunction

  // execution side may act when the buffer state matches its kind
  function automatic logic ind_ex_match(input ind_t v, input logic is_result);
    return is_result ? (v == IND_RSVD) : (v == IND_OPND);
  endfunction

endpackage

// File: rtl/obs_ring_ptr.sv
module obs_ring_ptr #(
  parameter int NBUF  = 4,
  parameter int PTR_W = $clog2(NBUF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NBUF - 1);

  function automatic logic [PTR_W-1:0] ring_next(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (step) ptr <= ring_next(ptr);
  end

endmodule

// File: rtl/obs_ind_cell.sv
module obs_ind_cell
  import obs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_data,
  input  logic clr_data,
  input  logic set_rsv,
  input  logic clr_all,
  output ind_t ind
);

  ind_t ind_nxt;

  // sets and clears from different sources merge bit by bit
  always_comb begin
    ind_nxt[1] = ((ind[1] & ~clr_data) | set_data) & ~clr_all;
    ind_nxt[0] = (ind[0] | set_rsv) & ~clr_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ind <= IND_FREE;
    else        ind <= ind_nxt;
  end

endmodule

// File: rtl/obs_wb_arb.sv
module obs_wb_arb
  import obs_pkg::*;
#(
  parameter int NBUF  = 4,
  parameter int PTR_W = $clog2(NBUF)
) (
  input  ind_t             st [NBUF],
  input  logic [PTR_W-1:0] start,
  output logic             req,
  output logic [PTR_W-1:0] idx
);

  function automatic logic [PTR_W-1:0] ring_add(input logic [PTR_W-1:0] base, input int k);
    int unsigned s;
    s = (int'(base) + k) % NBUF;
    return PTR_W'(s);
  endfunction

  // forward search from the oldest allocation position
  always_comb begin
    req = 1'b0;
    idx = '0;
    for (int k = 0; k < NBUF; k++) begin
      if (!req && ind_wants_wb(st[ring_add(start, k)])) begin
        req = 1'b1;
        idx = ring_add(start, k);
      end
    end
  end

endmodule

// File: rtl/obs_scoreboard.sv
module obs_scoreboard
  import obs_pkg::*;
#(
  parameter  int NBUF  = 4,
  localparam int PTR_W = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              la_valid,
  input  logic              la_write,
  output logic              la_ready,
  output logic [PTR_W-1:0]  la_ptr,
  input  logic              ex_valid,
  input  logic              ex_result,
  output logic              ex_ready,
  output logic [PTR_W-1:0]  ex_ptr,
  input  logic              mem_wr_ack,
  output logic              mem_wr_req,
  output logic [PTR_W-1:0]  mem_wr_idx,
  output logic [2*NBUF-1:0] buf_state
);

  ind_t st [NBUF];

  // named internal events
  logic la_fire;
  logic ex_fire;
  logic wb_fire;

  assign la_ready = ind_is_free(st[la_ptr]);
  assign ex_ready = ind_ex_match(st[ex_ptr], ex_result);
  assign la_fire  = la_valid & la_ready;
  assign ex_fire  = ex_valid & ex_ready;
  assign wb_fire  = mem_wr_req & mem_wr_ack;

  obs_ring_ptr #(.NBUF(NBUF), .PTR_W(PTR_W)) u_la_ptr (
    .clk(clk), .rst_n(rst_n), .step(la_fire), .ptr(la_ptr)
  );

  obs_ring_ptr #(.NBUF(NBUF), .PTR_W(PTR_W)) u_ex_ptr (
    .clk(clk), .rst_n(rst_n), .step(ex_fire), .ptr(ex_ptr)
  );

  generate
    for (genvar i = 0; i < NBUF; i++) begin : g_buf
      logic la_here, ex_here, wb_here;
      assign la_here = la_fire & (la_ptr == PTR_W'(i));
      assign ex_here = ex_fire & (ex_ptr == PTR_W'(i));
      assign wb_here = wb_fire & (mem_wr_idx == PTR_W'(i));

      obs_ind_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_data((la_here & ~la_write) | (ex_here & ex_result)),
        .clr_data(ex_here & ~ex_result),
        .set_rsv (la_here & la_write),
        .clr_all (wb_here),
        .ind     (st[i])
      );

      assign buf_state[2*i +: 2] = st[i];
    end
  endgenerate

  obs_wb_arb #(.NBUF(NBUF), .PTR_W(PTR_W)) u_arb (
    .st(st), .start(la_ptr), .req(mem_wr_req), .idx(mem_wr_idx)
  );

endmodule

// File: rtl/obs_scoreboard_chk.sv
module obs_scoreboard_chk #(
  parameter int NBUF  = 4,
  parameter int PTR_W = $clog2(NBUF)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              la_valid,
  input logic              la_write,
  input logic              la_ready,
  input logic [PTR_W-1:0]  la_ptr,
  input logic              ex_valid,
  input logic              ex_result,
  input logic              ex_ready,
  input logic [PTR_W-1:0]  ex_ptr,
  input logic              mem_wr_req,
  input logic [PTR_W-1:0]  mem_wr_idx,
  input logic [2*NBUF-1:0] buf_state,
  input logic              la_fire,
  input logic              ex_fire,
  input logic              wb_fire
);

  logic [1:0] cs [NBUF];
  for (genvar i = 0; i < NBUF; i++) begin : g_cs
    assign cs[i] = buf_state[2*i +: 2];
  end

  // R2
  la_load_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    la_fire && !la_write |=> cs[$past(la_ptr)] == 2'b10);

  // R3
  la_rsv_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    la_fire && la_write |=> cs[$past(la_ptr)] == 2'b01);

  // R4
  la_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    la_valid && !la_ready |=> $stable(la_ptr));

  // R5
  ex_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_fire && !ex_result |=> cs[$past(ex_ptr)] == 2'b00);

  // R6
  ex_deposit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_fire && ex_result |=> cs[$past(ex_ptr)] == 2'b11);

  // R7
  ex_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && !ex_ready |=> $stable(ex_ptr));

  // R8
  wb_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> cs[mem_wr_idx] == 2'b11);

  // R9
  wb_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |=> cs[$past(mem_wr_idx)] == 2'b00);

  // R11
  la_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    la_fire && $past(1'b1) |=> la_ptr == (($past(la_ptr) == PTR_W'(NBUF-1)) ? '0 : $past(la_ptr) + 1'b1));

endmodule

bind obs_scoreboard obs_scoreboard_chk #(.NBUF(NBUF), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .la_valid(la_valid), .la_write(la_write),
  .la_ready(la_ready), .la_ptr(la_ptr), .ex_valid(ex_valid), .ex_result(ex_result),
  .ex_ready(ex_ready), .ex_ptr(ex_ptr), .mem_wr_req(mem_wr_req),
  .mem_wr_idx(mem_wr_idx), .buf_state(buf_state), .la_fire(la_fire),
  .ex_fire(ex_fire), .wb_fire(wb_fire)
);

// File: tb/obs_scoreboard_test.sv
`timescale 1ns/1ps
module obs_scoreboard_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       la_valid = 1'b0, la_write = 1'b0;
  logic       ex_valid = 1'b0, ex_result = 1'b0;
  logic       mem_wr_ack = 1'b0;
  logic       la_ready, ex_ready, mem_wr_req;
  logic [1:0] la_ptr, ex_ptr, mem_wr_idx;
  logic [7:0] buf_state;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  obs_scoreboard uut (
    .clk(clk), .rst_n(rst_n), .la_valid(la_valid), .la_write(la_write),
    .la_ready(la_ready), .la_ptr(la_ptr), .ex_valid(ex_valid), .ex_result(ex_result),
    .ex_ready(ex_ready), .ex_ptr(ex_ptr), .mem_wr_ack(mem_wr_ack),
    .mem_wr_req(mem_wr_req), .mem_wr_idx(mem_wr_idx), .buf_state(buf_state)
  );

  // {la_valid la_write ex_valid ex_result ack} {b3 b2 b1 b0} la_ptr ex_ptr req idx
  localparam int NV = 21;
  localparam logic [19:0] VEC [NV] = '{
    {5'b10000, 8'b00_00_00_10, 2'd1, 2'd0, 1'b0, 2'd0},
    {5'b11000, 8'b00_00_01_10, 2'd2, 2'd0, 1'b0, 2'd0},
    {5'b10000, 8'b00_10_01_10, 2'd3, 2'd0, 1'b0, 2'd0},
    {5'b10100, 8'b10_10_01_00, 2'd0, 2'd1, 1'b0, 2'd0},
    {5'b10100, 8'b10_10_01_10, 2'd1, 2'd1, 1'b0, 2'd0},
    {5'b10110, 8'b10_10_11_10, 2'd1, 2'd2, 1'b1, 2'd1},
    {5'b11101, 8'b10_00_00_10, 2'd1, 2'd3, 1'b0, 2'd0},
    {5'b11100, 8'b00_00_01_10, 2'd2, 2'd0, 1'b0, 2'd0},
    {5'b11100, 8'b00_01_01_00, 2'd3, 2'd1, 1'b0, 2'd0},
    {5'b11110, 8'b01_01_11_00, 2'd0, 2'd2, 1'b1, 2'd1},
    {5'b10110, 8'b01_11_11_10, 2'd1, 2'd3, 1'b1, 2'd1},
    {5'b00110, 8'b11_11_11_10, 2'd1, 2'd0, 1'b1, 2'd1},
    {5'b00001, 8'b11_11_00_10, 2'd1, 2'd0, 1'b1, 2'd2},
    {5'b10001, 8'b11_00_10_10, 2'd2, 2'd0, 1'b1, 2'd3},
    {5'b11101, 8'b00_01_10_00, 2'd3, 2'd1, 1'b0, 2'd0},
    {5'b11100, 8'b01_01_00_00, 2'd0, 2'd2, 1'b0, 2'd0},
    {5'b11110, 8'b01_11_00_01, 2'd1, 2'd3, 1'b1, 2'd2},
    {5'b00111, 8'b11_00_00_01, 2'd1, 2'd0, 1'b1, 2'd3},
    {5'b00110, 8'b11_00_00_11, 2'd1, 2'd1, 1'b1, 2'd3},
    {5'b00001, 8'b00_00_00_11, 2'd1, 2'd1, 1'b1, 2'd0},
    {5'b00001, 8'b00_00_00_00, 2'd1, 2'd1, 1'b0, 2'd0}
  };

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 state", buf_state, 0);
    check("R1 la_ptr", la_ptr, 0);
    check("R1 ex_ptr", ex_ptr, 0);
    check("R1 req", mem_wr_req, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      {la_valid, la_write, ex_valid, ex_result, mem_wr_ack} = VEC[v][19:15];
      @(negedge clk);
      check($sformatf("R2/R3/R5/R6/R9/R10 state v%0d", v), buf_state, VEC[v][14:7]);
      check($sformatf("R4/R11 la_ptr v%0d", v), la_ptr, VEC[v][6:5]);
      check($sformatf("R7/R11 ex_ptr v%0d", v), ex_ptr, VEC[v][4:3]);
      check($sformatf("R8 req v%0d", v), mem_wr_req, VEC[v][2]);
      if (VEC[v][2]) check($sformatf("R8 idx v%0d", v), mem_wr_idx, VEC[v][1:0]);
    end

    {la_valid, la_write, ex_valid, ex_result, mem_wr_ack} = 5'b00000;
    #1;
    check("R4 la_ready on free buffer", la_ready, 1);
    ex_valid = 1'b1; ex_result = 1'b0;
    #1;
    check("R7 ex_ready on free buffer", ex_ready, 0);
    ex_valid = 1'b0;

    // mid-run reset
    @(negedge clk);
    la_valid = 1'b1;
    @(negedge clk);
    la_valid = 1'b0;
    check("R2 load before reset", buf_state, 8'b00_00_10_00);
    rst_n = 1'b0;
    #1;
    check("R1 state after reset", buf_state, 0);
    check("R1 la_ptr after reset", la_ptr, 0);
    check("R1 req after reset", mem_wr_req, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule